// File: doc/BRIEF.md
# SD descriptor chain command sequencer

This block drives an SD bus engine from a list of command descriptors held in memory. Software writes a base address with the go bit set. The sequencer then fetches each 16-byte descriptor one word at a time and checks its ownership. It hands the command, argument, data and response addresses and the transfer length to the bus engine, and waits for the engine to finish. It then writes the flags word back with ownership returned. Each descriptor is laid out as flags, argument, data address and response address, in that order. The sequencer moves 16 bytes forward after each descriptor. It stops after a descriptor marked as the last, or when an error, a timeout or a stop write occurs.

A second path needs no memory. Software writes a flags word and a data address into holding registers. Writing the argument register then issues one command directly. The bus signalling, CRC and the data movement belong to the engine, which sits outside this block.

Top module: `sd_desc_seq`

## Requirements
- R1: After reset, `busy`, `opValid`, `memReq` and all four event outputs are low.
- R2: A register write to address 0 with bit 1 set, while idle, starts a chain at the written address with bits 1:0 forced to zero. Each descriptor is read as four words at offsets 0, 4, 8 and 12, in that order. The operation is then presented with command index = flags[29:24], plus the argument, data address and response address words.
- R3: `opXferLen` decodes flags[8:0], where 0 stands for 512. When flags[9] (block mode) is set, the length in bytes is that count shifted left by `cfgBlkLog2`. Otherwise it is that count in bytes.
- R4: When the engine finishes, the flags word is written back to the descriptor's own address (offset 0). In the written word, bit 31 is cleared and bit 30 equals the engine's error result. Bits 29:0 are unchanged.
- R5: After a successful descriptor, the next descriptor is fetched 16 bytes further on. If flags[11] (end of chain) is set, the sequencer goes idle after the writeback and pulses `evtEndChain` once.
- R6: If the owner bit (flags[31]) is clear and `cfgIgnoreOwner` is low, the chain stops with one `evtDescErr` pulse, with no operation and no writeback. If `cfgIgnoreOwner` is high, the descriptor is processed normally.
- R7: If the engine reports `opErr` along with `opDone`, the writeback carries the error bit. `evtCmdErr` then pulses once and no further descriptor is fetched. For a direct command, the error causes `evtCmdErr` and no `evtEndChain`.
- R8: While an operation waits, each `tickMs` pulse counts one millisecond. When 2^flags[15:12] ticks pass without `opDone`, `opValid` drops, the chain stops without a writeback, and `evtTimeout` pulses once.
- R9: A register write of 0 to address 0 while busy returns the sequencer to idle in the next cycle. `opValid` and `memReq` drop and no event is raised.
- R10: Register address 1 holds the direct flags word and address 2 holds the direct data address. A write to address 3 while idle issues one operation from these values, with the written argument and a response address of 0. It makes no memory access. A successful direct command pulses `evtEndChain`.
- R11: A descriptor with flags[9] and flags[18] (data phase) both set is rejected with `evtDescErr` when `cfgBlkLog2` is above 9, which means blocks longer than 512 bytes. It produces no operation and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 start/stop, 1 direct flags, 2 direct data address, 3 direct argument (launch) |
| regWrData | input | 32 | Register write data |
| cfgIgnoreOwner | input | 1 | Process descriptors even when the owner bit is clear |
| cfgBlkLog2 | input | 4 | Block length as log2 of bytes |
| tickMs | input | 1 | One-cycle pulse per millisecond |
| memReq | output | 1 | Memory word request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completed; read data valid |
| memRdata | input | 32 | Read data |
| opValid | output | 1 | Operation request to the bus engine |
| opCmdIdx | output | 6 | Command index |
| opFlags | output | 32 | Full flags word of the operation |
| opArg | output | 32 | Command argument |
| opDataAddr | output | 32 | Data buffer address |
| opRespAddr | output | 32 | Response address |
| opXferLen | output | 19 | Transfer length in bytes |
| opDone | input | 1 | Engine finished the operation |
| opErr | input | 1 | Engine result was an error, valid with opDone |
| busy | output | 1 | Sequencer active |
| evtEndChain | output | 1 | Pulse: chain or direct command completed |
| evtDescErr | output | 1 | Pulse: descriptor rejected |
| evtCmdErr | output | 1 | Pulse: engine reported an error |
| evtTimeout | output | 1 | Pulse: descriptor timeout expired |

## Verification
The hardest situation to reach is a timeout or a stop that lands while an operation is held open. That needs an engine that never answers, and a stop write timed against a request that is still pending. The bench model of the engine has a hang switch. A free-running millisecond tick then makes the 2^n window short enough to count cycles exactly. For the stop case, the bench waits for `opValid` before writing zero. A rejected descriptor in the middle of a chain is reached by placing a good descriptor ahead of a bad one. This shows that the first one is written back and the second one is not.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;
  // flag word bit positions the sequencer decodes
  localparam int FL_OWNER  = 31;
  localparam int FL_ERR    = 30;
  localparam int FL_CMD_LO = 24;
  localparam int FL_DATA   = 18;
  localparam int FL_TMO_LO = 12;
  localparam int FL_EOC    = 11;
  localparam int FL_BLK    = 9;
  localparam int DESC_WORDS = 4;
  localparam int MAX_BLK_LOG2 = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_WB
  } seqState_t;

  typedef struct packed {
    logic ldBase;
    logic ldImm;
    logic ldWord;
    logic advPtr;
    logic clrTimer;
    logic runTimer;
  } seqStrb_t;
endpackage

// File: rtl/sd_seq_datapath.sv
module sd_seq_datapath import sd_seq_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TMR_W = 16,
  parameter int LEN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrb_t         strb,
  input  logic [1:0]       wordIdx,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic [DW-1:0]    memRdata,
  input  logic             tickMs,
  input  logic [3:0]       cfgBlkLog2,
  input  logic             wbErr,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic [DW-1:0]    descFlags,
  output logic [DW-1:0]    opArg,
  output logic [AW-1:0]    opDataAddr,
  output logic [AW-1:0]    opRespAddr,
  output logic [LEN_W-1:0] opXferLen,
  output logic             timeoutHit,
  output logic             blkTooBig
);
  localparam int UNIT_W = 10;
  localparam logic [UNIT_W-1:0] FULL_UNITS = UNIT_W'(512);

  logic [DW-1:0]    descWord [DESC_WORDS];
  logic [DW-1:0]    immVal   [DESC_WORDS];
  logic [DW-1:0]    immFlags, immData;
  logic [AW-1:0]    ptr;
  logic [TMR_W-1:0] tmrCnt, tmrLimitM1;
  logic [UNIT_W-1:0] lenUnits;

  // direct-command holding registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      immFlags <= '0;
      immData  <= '0;
    end else if (regWr) begin
      if (regAddr == 2'd1) immFlags <= regWrData;
      if (regAddr == 2'd2) immData  <= regWrData;
    end
  end

  always_comb begin
    immVal[0] = immFlags;
    immVal[1] = regWrData;
    immVal[2] = immData;
    immVal[3] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DESC_WORDS; w++) descWord[w] <= '0;
    end else begin
      for (int w = 0; w < DESC_WORDS; w++) begin
        if (strb.ldWord && wordIdx == 2'(w)) descWord[w] <= memRdata;
        else if (strb.ldImm)                 descWord[w] <= immVal[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           ptr <= '0;
    else if (strb.ldBase) ptr <= {regWrData[AW-1:2], 2'b00};
    else if (strb.advPtr) ptr <= ptr + AW'(DESC_WORDS * 4);
  end

  // millisecond timeout counter
  assign tmrLimitM1 = (TMR_W'(1) << descWord[0][FL_TMO_LO +: 4]) - TMR_W'(1);
  assign timeoutHit = strb.runTimer && tickMs && (tmrCnt == tmrLimitM1);

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clrTimer)      tmrCnt <= '0;
    else if (strb.runTimer && tickMs) tmrCnt <= tmrCnt + TMR_W'(1);
  end

  assign lenUnits  = (descWord[0][8:0] == 9'd0) ? FULL_UNITS : {1'b0, descWord[0][8:0]};
  assign opXferLen = descWord[0][FL_BLK] ? (LEN_W'(lenUnits) << cfgBlkLog2) : LEN_W'(lenUnits);
  assign blkTooBig = descWord[0][FL_BLK] && descWord[0][FL_DATA] && (cfgBlkLog2 > 4'(MAX_BLK_LOG2));

  assign memAddr    = ptr + AW'({wordIdx, 2'b00});
  assign memWdata   = {1'b0, wbErr, descWord[0][FL_ERR-1:0]};
  assign descFlags  = descWord[0];
  assign opArg      = descWord[1];
  assign opDataAddr = descWord[2];
  assign opRespAddr = descWord[3];
endmodule

// File: rtl/sd_seq_control.sv
module sd_seq_control import sd_seq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       goWr,
  input  logic       stopWr,
  input  logic       immWr,
  input  logic       memAck,
  input  logic       opDone,
  input  logic       opErr,
  input  logic       timeoutHit,
  input  logic       descOwner,
  input  logic       descEoc,
  input  logic       cfgIgnoreOwner,
  input  logic       blkTooBig,
  output seqStrb_t   strb,
  output logic [1:0] wordIdx,
  output logic       memReq,
  output logic       memWe,
  output logic       opValid,
  output logic       wbErr,
  output logic       busy,
  output logic       evtEndChain,
  output logic       evtDescErr,
  output logic       evtCmdErr,
  output logic       evtTimeout
);
  seqState_t state, nxt;
  logic immMode, errLat, idxInc;
  logic eEnd, eDesc, eCmd, eTmo;

  always_comb begin
    nxt = state;
    strb = '0;
    memReq = 1'b0;
    memWe = 1'b0;
    opValid = 1'b0;
    idxInc = 1'b0;
    {eEnd, eDesc, eCmd, eTmo} = '0;
    case (state)
      S_IDLE: begin
        if (goWr) begin
          strb.ldBase = 1'b1;
          nxt = S_FETCH;
        end else if (immWr) begin
          strb.ldImm = 1'b1;
          strb.clrTimer = 1'b1;
          nxt = S_ISSUE;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.ldWord = 1'b1;
          idxInc = 1'b1;
          if (wordIdx == 2'd3) nxt = S_CHECK;
        end
      end
      S_CHECK: begin
        if ((!descOwner && !cfgIgnoreOwner) || blkTooBig) begin
          eDesc = 1'b1;
          nxt = S_IDLE;
        end else begin
          strb.clrTimer = 1'b1;
          nxt = S_ISSUE;
        end
      end
      S_ISSUE: begin
        opValid = 1'b1;
        strb.runTimer = 1'b1;
        if (opDone) begin
          if (immMode) begin
            eCmd = opErr;
            eEnd = !opErr;
            nxt = S_IDLE;
          end else begin
            nxt = S_WB;
          end
        end else if (timeoutHit) begin
          eTmo = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_WB: begin
        memReq = 1'b1;
        memWe = 1'b1;
        if (memAck) begin
          if (errLat) begin
            eCmd = 1'b1;
            nxt = S_IDLE;
          end else if (descEoc) begin
            eEnd = 1'b1;
            nxt = S_IDLE;
          end else begin
            strb.advPtr = 1'b1;
            nxt = S_FETCH;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (stopWr && state != S_IDLE) begin
      nxt = S_IDLE;
      {eEnd, eDesc, eCmd, eTmo} = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wordIdx <= '0;
      immMode <= 1'b0;
      errLat <= 1'b0;
      {evtEndChain, evtDescErr, evtCmdErr, evtTimeout} <= '0;
    end else begin
      state <= nxt;
      if (strb.ldBase) wordIdx <= '0;
      else if (idxInc) wordIdx <= wordIdx + 2'd1;
      if (strb.ldBase) immMode <= 1'b0;
      else if (strb.ldImm) immMode <= 1'b1;
      if (state == S_ISSUE && opDone) errLat <= opErr;
      {evtEndChain, evtDescErr, evtCmdErr, evtTimeout} <= {eEnd, eDesc, eCmd, eTmo};
    end
  end

  assign busy  = (state != S_IDLE);
  assign wbErr = errLat;

  p_done_leaves_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opDone && !stopWr) |=> !opValid);
  p_timeout_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evtTimeout |-> (!opValid && !busy));
  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evtEndChain |-> !busy);
  p_desc_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evtDescErr |-> (!opValid && !memReq));
endmodule

// File: rtl/sd_desc_seq.sv
module sd_desc_seq import sd_seq_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TMR_W = 16,
  parameter int LEN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic             cfgIgnoreOwner,
  input  logic [3:0]       cfgBlkLog2,
  input  logic             tickMs,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic             memAck,
  input  logic [DW-1:0]    memRdata,
  output logic             opValid,
  output logic [5:0]       opCmdIdx,
  output logic [DW-1:0]    opFlags,
  output logic [DW-1:0]    opArg,
  output logic [AW-1:0]    opDataAddr,
  output logic [AW-1:0]    opRespAddr,
  output logic [LEN_W-1:0] opXferLen,
  input  logic             opDone,
  input  logic             opErr,
  output logic             busy,
  output logic             evtEndChain,
  output logic             evtDescErr,
  output logic             evtCmdErr,
  output logic             evtTimeout
);
  seqStrb_t   strb;
  logic [1:0] wordIdx;
  logic       wbErr, timeoutHit, blkTooBig;
  logic       goWr, stopWr, immWr;
  logic [DW-1:0] descFlags;

  assign goWr   = regWr && regAddr == 2'd0 && regWrData[1];
  assign stopWr = regWr && regAddr == 2'd0 && regWrData == '0;
  assign immWr  = regWr && regAddr == 2'd3;

  sd_seq_control u_ctl (
    .clk, .rst_n, .goWr, .stopWr, .immWr, .memAck, .opDone, .opErr, .timeoutHit,
    .descOwner(descFlags[FL_OWNER]), .descEoc(descFlags[FL_EOC]),
    .cfgIgnoreOwner, .blkTooBig, .strb, .wordIdx, .memReq, .memWe, .opValid,
    .wbErr, .busy, .evtEndChain, .evtDescErr, .evtCmdErr, .evtTimeout
  );

  sd_seq_datapath #(.AW(AW), .DW(DW), .TMR_W(TMR_W), .LEN_W(LEN_W)) u_dp (
    .clk, .rst_n, .strb, .wordIdx, .regWr, .regAddr, .regWrData, .memRdata,
    .tickMs, .cfgBlkLog2, .wbErr, .memAddr, .memWdata, .descFlags, .opArg,
    .opDataAddr, .opRespAddr, .opXferLen, .timeoutHit, .blkTooBig
  );

  assign opFlags  = descFlags;
  assign opCmdIdx = descFlags[FL_CMD_LO +: 6];

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !regWr) |=> (memReq && $stable(memAddr)));
  p_wb_at_desc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> (memAddr[3:0] == 4'd0));
endmodule

// File: tb/sd_desc_seq_tb_top.sv
module sd_desc_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic cfgIgnoreOwner = 1'b0;
  logic [3:0] cfgBlkLog2 = 4'd9;
  logic tickMs = 1'b0;
  logic memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic opValid, opDone, opErr, busy;
  logic [5:0] opCmdIdx;
  logic [31:0] opFlags, opArg, opDataAddr, opRespAddr;
  logic [18:0] opXferLen;
  logic evtEndChain, evtDescErr, evtCmdErr, evtTimeout;

  always #2 clk = ~clk;

  sd_desc_seq dut_i (.*);

  int nChecks = 0, nErr = 0, cyc = 0, opHiCnt = 0;
  string curReq = "R1";
  logic [31:0] mem [0:255];
  int engCnt = 0, engDelay = 2;
  bit engErr = 0, engHang = 0;

  // reference expectations
  logic [31:0] eAddr[$], eWd[$];
  bit eWe[$];
  logic [31:0] oIdx[$], oArg[$], oDat[$], oRsp[$], oLen[$];
  int evQ[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: ack one cycle after request
  always @(posedge clk) begin
    if (!rst_n) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        memRdata <= mem[memAddr[9:2]];
        if (memWe) mem[memAddr[9:2]] <= memWdata;
      end
    end
  end

  // bus engine model
  always @(posedge clk) begin
    if (!rst_n) begin
      opDone <= 1'b0;
      opErr <= 1'b0;
      engCnt <= 0;
    end else begin
      opDone <= 1'b0;
      if (opValid && !opDone && !engHang) begin
        if (engCnt >= engDelay) begin
          opDone <= 1'b1;
          opErr <= engErr;
          engCnt <= 0;
        end else engCnt <= engCnt + 1;
      end else engCnt <= 0;
    end
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nErr++;
      $display("FAIL %s watchdog: actual %0d expected below %0d", curReq, cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
    if (rst_n) begin
      if (opValid) opHiCnt++;
      if (memReq && memAck) begin
        if (eAddr.size() == 0) chk(0, curReq, "unexpected memory access", memAddr, 0);
        else begin
          logic [31:0] a, d; bit w;
          a = eAddr.pop_front(); w = eWe.pop_front(); d = eWd.pop_front();
          chk(memAddr == a, curReq, "memory address", memAddr, a);
          chk(memWe == w, curReq, "memory write flag", memWe, w);
          if (w) chk(memWdata == d, curReq, "writeback word", memWdata, d);
        end
      end
      if (opValid && opDone) begin
        if (oIdx.size() == 0) chk(0, curReq, "unexpected operation", opCmdIdx, 0);
        else begin
          logic [31:0] i, ar, da, rs, ln;
          i = oIdx.pop_front(); ar = oArg.pop_front(); da = oDat.pop_front();
          rs = oRsp.pop_front(); ln = oLen.pop_front();
          chk(opCmdIdx == i[5:0], curReq, "command index", opCmdIdx, i);
          chk(opArg == ar, curReq, "argument", opArg, ar);
          chk(opDataAddr == da, curReq, "data address", opDataAddr, da);
          chk(opRespAddr == rs, curReq, "response address", opRespAddr, rs);
          chk(32'(opXferLen) == ln, curReq, "transfer length", opXferLen, ln);
        end
      end
      begin
        int code;
        code = evtEndChain ? 1 : evtDescErr ? 2 : evtCmdErr ? 3 : evtTimeout ? 4 : 0;
        if (code != 0) begin
          if (evQ.size() == 0) chk(0, curReq, "unexpected event", code, 0);
          else begin
            int e;
            e = evQ.pop_front();
            chk(code == e, curReq, "event code", code, e);
          end
        end
      end
    end
  end

  function automatic logic [31:0] mkFlags(bit own, int cmd, bit rsp, bit dat, bit nocmd,
                                          int tmo, bit eoc, bit blk, int len);
    return {own, 1'b0, 6'(cmd), 1'b0, rsp, 1'b0, 1'b0, 1'b0, dat, nocmd, ~rsp,
            4'(tmo), eoc, 1'b0, blk, 9'(len)};
  endfunction

  task automatic writeReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic putDesc(int base, logic [31:0] f, logic [31:0] a, logic [31:0] d, logic [31:0] r);
    mem[base/4] = f; mem[base/4+1] = a; mem[base/4+2] = d; mem[base/4+3] = r;
  endtask

  task automatic expFetch(int base);
    for (int k = 0; k < 4; k++) begin
      eAddr.push_back(32'(base + 4*k)); eWe.push_back(0); eWd.push_back('0);
    end
  endtask

  task automatic expWb(int base, logic [31:0] f, bit err);
    eAddr.push_back(32'(base)); eWe.push_back(1); eWd.push_back({1'b0, err, f[29:0]});
  endtask

  // R3 length rule computed from the requirement text
  task automatic expOp(logic [31:0] f, logic [31:0] a, logic [31:0] d, logic [31:0] r);
    int units, bytes;
    units = (f[8:0] == 0) ? 512 : int'(f[8:0]);
    bytes = f[9] ? units * (2 ** int'(cfgBlkLog2)) : units;
    oIdx.push_back(32'(f[29:24])); oArg.push_back(a); oDat.push_back(d);
    oRsp.push_back(r); oLen.push_back(32'(bytes));
  endtask

  task automatic waitDone();
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 0, curReq, "idle at end", busy, 0);
    chk(eAddr.size() == 0, curReq, "memory accesses left", eAddr.size(), 0);
    chk(oIdx.size() == 0, curReq, "operations left", oIdx.size(), 0);
    chk(evQ.size() == 0, curReq, "events left", evQ.size(), 0);
  endtask

  initial begin
    logic [31:0] f0, f1, f2;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    curReq = "R1";
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(opValid == 0, "R1", "opValid after reset", opValid, 0);
    chk(memReq == 0, "R1", "memReq after reset", memReq, 0);
    chk({evtEndChain, evtDescErr, evtCmdErr, evtTimeout} == 0, "R1", "events after reset",
        {evtEndChain, evtDescErr, evtCmdErr, evtTimeout}, 0);

    // R2 R3 R4 R5: three-descriptor chain, low address bits ignored
    curReq = "R2/R3/R4/R5";
    f0 = mkFlags(1, 17, 1, 1, 0, 12, 0, 1, 2);
    f1 = mkFlags(1, 18, 1, 1, 1, 12, 0, 0, 0);
    f2 = mkFlags(1, 12, 0, 0, 0, 12, 1, 0, 5);
    putDesc(32'h40, f0, 32'h1111, 32'h2000, 32'h3000);
    putDesc(32'h50, f1, 32'h2222, 32'h2400, 32'h3010);
    putDesc(32'h60, f2, 32'h3333, 32'h0, 32'h3020);
    expFetch(32'h40); expOp(f0, 32'h1111, 32'h2000, 32'h3000); expWb(32'h40, f0, 0);
    expFetch(32'h50); expOp(f1, 32'h2222, 32'h2400, 32'h3010); expWb(32'h50, f1, 0);
    expFetch(32'h60); expOp(f2, 32'h3333, 32'h0, 32'h3020); expWb(32'h60, f2, 0);
    evQ.push_back(1);
    writeReg(2'd0, 32'h43);
    waitDone();

    // R6: second descriptor not owned stops the chain
    curReq = "R6";
    f0 = mkFlags(1, 5, 1, 0, 0, 12, 0, 0, 8);
    f1 = mkFlags(0, 6, 1, 0, 0, 12, 1, 0, 8);
    putDesc(32'h100, f0, 32'hA, 32'hB, 32'hC);
    putDesc(32'h110, f1, 32'hD, 32'hE, 32'hF);
    expFetch(32'h100); expOp(f0, 32'hA, 32'hB, 32'hC); expWb(32'h100, f0, 0);
    expFetch(32'h110); evQ.push_back(2);
    writeReg(2'd0, 32'h102);
    waitDone();

    // R6: ignore-owner processes the same chain to its end
    curReq = "R6";
    cfgIgnoreOwner = 1'b1;
    putDesc(32'h100, f0, 32'hA, 32'hB, 32'hC);
    expFetch(32'h100); expOp(f0, 32'hA, 32'hB, 32'hC); expWb(32'h100, f0, 0);
    expFetch(32'h110); expOp(f1, 32'hD, 32'hE, 32'hF); expWb(32'h110, f1, 0);
    evQ.push_back(1);
    writeReg(2'd0, 32'h102);
    waitDone();
    cfgIgnoreOwner = 1'b0;

    // R7: engine error stops the chain, error bit written back
    curReq = "R7";
    engErr = 1;
    f0 = mkFlags(1, 24, 1, 1, 0, 12, 0, 1, 1);
    putDesc(32'h200, f0, 32'h55, 32'h66, 32'h77);
    putDesc(32'h210, mkFlags(1, 25, 1, 0, 0, 12, 1, 0, 1), 0, 0, 0);
    expFetch(32'h200); expOp(f0, 32'h55, 32'h66, 32'h77); expWb(32'h200, f0, 1);
    evQ.push_back(3);
    writeReg(2'd0, 32'h202);
    waitDone();
    engErr = 0;

    // R8: hung engine, 2^2 ticks with a tick every cycle
    curReq = "R8";
    engHang = 1; tickMs = 1'b1;
    f0 = mkFlags(1, 7, 1, 0, 0, 2, 1, 0, 4);
    putDesc(32'h300, f0, 32'h1, 32'h2, 32'h3);
    expFetch(32'h300); evQ.push_back(4);
    opHiCnt = 0;
    writeReg(2'd0, 32'h302);
    waitDone();
    chk(opHiCnt == 4, "R8", "cycles opValid held", opHiCnt, 4);
    chk(opValid == 0, "R8", "opValid after timeout", opValid, 0);
    tickMs = 1'b0;

    // R9: stop write while the operation is pending
    curReq = "R9";
    f0 = mkFlags(1, 9, 1, 0, 0, 12, 1, 0, 4);
    putDesc(32'h300, f0, 32'h1, 32'h2, 32'h3);
    expFetch(32'h300);
    writeReg(2'd0, 32'h302);
    for (int k = 0; k < 100 && !opValid; k++) @(negedge clk);
    chk(opValid == 1, "R9", "operation pending before stop", opValid, 1);
    writeReg(2'd0, 32'h0);
    chk(busy == 0, "R9", "busy after stop", busy, 0);
    chk(opValid == 0, "R9", "opValid after stop", opValid, 0);
    waitDone();
    engHang = 0;

    // R10: direct command launched by the argument write
    curReq = "R10";
    f0 = mkFlags(0, 8, 1, 0, 0, 12, 0, 0, 7);
    writeReg(2'd1, f0);
    writeReg(2'd2, 32'h1234);
    expOp(f0, 32'hABCD, 32'h1234, 32'h0); evQ.push_back(1);
    writeReg(2'd3, 32'hABCD);
    waitDone();

    // R7: direct command with an engine error
    curReq = "R7";
    engErr = 1;
    expOp(f0, 32'h77, 32'h1234, 32'h0); evQ.push_back(3);
    writeReg(2'd3, 32'h77);
    waitDone();
    engErr = 0;

    // R11: block length above 512 bytes rejected
    curReq = "R11";
    cfgBlkLog2 = 4'd10;
    f0 = mkFlags(1, 18, 1, 1, 0, 12, 1, 1, 1);
    putDesc(32'h380, f0, 32'h9, 32'h9, 32'h9);
    expFetch(32'h380); evQ.push_back(2);
    writeReg(2'd0, 32'h382);
    waitDone();
    chk(mem[32'h380/4] == f0, "R11", "descriptor untouched", mem[32'h380/4], f0);

    // R3: block mode with a smaller block length
    curReq = "R3";
    cfgBlkLog2 = 4'd2;
    f0 = mkFlags(1, 3, 0, 1, 0, 12, 1, 1, 0);
    putDesc(32'h3C0, f0, 32'h4, 32'h5, 32'h6);
    expFetch(32'h3C0); expOp(f0, 32'h4, 32'h5, 32'h6); expWb(32'h3C0, f0, 0);
    evQ.push_back(1);
    writeReg(2'd0, 32'h3C2);
    waitDone();

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule